// File: doc/BRIEF.md
# Tree-Sharer Cache Line Coherence Controller

This block runs the coherence state of one cache line in a node whose sharers are organised as trees, with each line able to act as an interior node holding at most two children. A read miss asks the home node for the line. The data reply may carry up to two child node numbers, which the line keeps. Later, a regular invalidation arriving from the parent is pushed down to those children. The line then waits for each child to acknowledge before it acknowledges upward to the node that invalidated it, so acknowledgements retrace the invalidation path.

When the line is evicted, it sends a replacement invalidation to its children and does not inform the home node. A node that receives a replacement invalidation drops its copy, forwards the same message to its own children, and sends no acknowledgement. A processor miss that evicts a live line performs this eviction step in the same cycle as it sends its request to the home node. Writing to a line held only as Valid is handled as an eviction followed by a write miss. Data arrays, tag lookup, the network and the directory are not part of this block.

The line state is encoded as Invalid=0, Valid=1, Exclusive=2, read-miss-pending=3, write-miss-pending=4 and invalidation-pending=5. Child masks use bit 0 for child A and bit 1 for child B. Message inputs are single-cycle pulses.

Top module: `tree_line_ctl`

## Requirements
- R1: After reset, line_st is 0 and kid_vld is 0. In the same state, req_rd, req_wr, inv_out, rinv_out and ack_out are all 0.
- R2: In state 0, cpu_rd raises req_rd in the same cycle, and the next state is 3. In state 0, cpu_wr raises req_wr in the same cycle, and the next state is 4.
- R3: A data reply (msg_data) in state 3 moves the line to state 1 and latches msg_kid_vld, msg_kid_a and msg_kid_b. A data reply in state 4 moves the line to state 2 with kid_vld 0.
- R4: An INV in state 1 or 2 with kid_vld 0 raises ack_out in the same cycle, with ack_dst equal to msg_inv_src. inv_out stays 0, and the next state is 0.
- R5: An INV in state 1 or 2 with a nonzero kid_vld drives inv_out equal to kid_vld in the same cycle. ack_out stays 0, and the next state is 5.
- R6: In state 5, ack_out rises only on the acknowledgement that completes the count of children that were present. At that point ack_dst equals the source of the INV that was held, and the next state is 0 with kid_vld 0.
- R7: A Replace-INV in state 1 or 2 drives rinv_out equal to kid_vld and never raises ack_out. The next state is 0 with kid_vld 0.
- R8: cpu_evict in state 1 or 2 drives rinv_out equal to kid_vld. If cpu_rd or cpu_wr is asserted in the same cycle, the matching request is raised in that cycle and the next state is 3 or 4. With no request, the next state is 0.
- R9: cpu_wr in state 1 sends Replace-INV to the children and raises req_wr, and the next state is 4. cpu_wr and cpu_rd in state 2, and cpu_rd in state 1, raise no request and leave the state unchanged.
- R10: An INV that arrives in state 3 produces no ack_out and no inv_out while the miss is pending. In the first cycle in state 1 after the data reply, it is handled as in R4 or R5, using its original source.
- R11: Processor requests have no effect in states 3, 4 and 5. In states 1 and 2, an INV or Replace-INV in the same cycle takes priority, and the processor request is dropped.
- R12: An INV in state 0 or 4 raises ack_out in the same cycle, with ack_dst equal to msg_inv_src, and leaves the state unchanged. A Replace-INV in state 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | Processor read access to this line |
| cpu_wr | input | 1 | Processor write access to this line |
| cpu_evict | input | 1 | Line is the victim of a miss to another address, or is being replaced |
| msg_data | input | 1 | Data reply from home |
| msg_kid_vld | input | 2 | Valid mask for the child pointers in the reply |
| msg_kid_a | input | NODE_W | Child A node number in the reply |
| msg_kid_b | input | NODE_W | Child B node number in the reply |
| msg_inv | input | 1 | Regular invalidation received |
| msg_inv_src | input | NODE_W | Sender of the invalidation |
| msg_rinv | input | 1 | Replacement invalidation received |
| msg_ack | input | 1 | Acknowledgement from a child |
| req_rd | output | 1 | Read request to home |
| req_wr | output | 1 | Write request to home |
| inv_out | output | 2 | INV sent to each child (bit per child) |
| rinv_out | output | 2 | Replace-INV sent to each child (bit per child) |
| ack_out | output | 1 | Acknowledgement sent upward |
| ack_dst | output | NODE_W | Destination of the acknowledgement |
| kid_a | output | NODE_W | Stored child A node number |
| kid_b | output | NODE_W | Stored child B node number |
| kid_vld | output | 2 | Stored child valid mask |
| line_st | output | 3 | Line state code |

## Verification
The bench repeats each scenario for all four child masks and computes the expected fan-out and acknowledgement count from the mask. This catches a counter loaded with the wrong number of children, which would acknowledge early or hang in state 5. It also delivers an INV during a pending read miss, with child sets both empty and full. A design that answered at once would acknowledge before it had data; a design that dropped the INV would leave a stale copy with no ack. Replace-INV, eviction and stale invalidations are checked so that an acknowledgement on the replacement path shows up, and so does a missing acknowledgement for an INV aimed at a line already dropped. Same-cycle collisions between processor requests and incoming invalidations expose a request that leaks out during invalidation.

// File: rtl/tree_line_ctl.sv
module tree_line_ctl #(
  parameter int NODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              cpu_evict,
  input  logic              msg_data,
  input  logic [1:0]        msg_kid_vld,
  input  logic [NODE_W-1:0] msg_kid_a,
  input  logic [NODE_W-1:0] msg_kid_b,
  input  logic              msg_inv,
  input  logic [NODE_W-1:0] msg_inv_src,
  input  logic              msg_rinv,
  input  logic              msg_ack,
  output logic              req_rd,
  output logic              req_wr,
  output logic [1:0]        inv_out,
  output logic [1:0]        rinv_out,
  output logic              ack_out,
  output logic [NODE_W-1:0] ack_dst,
  output logic [NODE_W-1:0] kid_a,
  output logic [NODE_W-1:0] kid_b,
  output logic [1:0]        kid_vld,
  output logic [2:0]        line_st
);
  typedef enum logic [2:0] {
    ST_I = 3'd0, ST_V = 3'd1, ST_E = 3'd2,
    ST_RMIP = 3'd3, ST_WMIP = 3'd4, ST_INVIP = 3'd5
  } st_t;

  st_t st;
  logic [1:0] kv, cnt;
  logic [NODE_W-1:0] ka, kb, up, pend_src;
  logic pend;

  logic stable, inv_now, inv_stale, rinv_now, cpu_go, victim, miss_rd, miss_wr, last_ack;
  logic [NODE_W-1:0] inv_src;

  assign stable    = (st == ST_V) || (st == ST_E);
  assign inv_now   = stable && (msg_inv || pend);
  assign inv_src   = pend ? pend_src : msg_inv_src;
  assign inv_stale = msg_inv && ((st == ST_I) || (st == ST_WMIP));
  assign rinv_now  = stable && !inv_now && msg_rinv;
  assign cpu_go    = !inv_now && !rinv_now;
  assign victim    = stable && cpu_go && (cpu_evict || (cpu_wr && st == ST_V));
  assign miss_wr   = cpu_go && cpu_wr && ((st == ST_I) || (stable && (cpu_evict || st == ST_V)));
  assign miss_rd   = cpu_go && cpu_rd && !cpu_wr && ((st == ST_I) || (stable && cpu_evict));
  assign last_ack  = (st == ST_INVIP) && msg_ack && (cnt == 2'd1);

  assign req_rd   = miss_rd;
  assign req_wr   = miss_wr;
  assign inv_out  = inv_now ? kv : 2'b00;
  assign rinv_out = (rinv_now || victim) ? kv : 2'b00;
  assign ack_out  = (inv_now && kv == 2'b00) || inv_stale || last_ack;
  assign ack_dst  = (st == ST_INVIP) ? up : inv_src;
  assign kid_a    = ka;
  assign kid_b    = kb;
  assign kid_vld  = kv;
  assign line_st  = st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_I;
      kv <= '0;
      ka <= '0;
      kb <= '0;
      cnt <= '0;
      up <= '0;
      pend <= 1'b0;
      pend_src <= '0;
    end else begin
      case (st)
        ST_I: begin
          if (miss_wr) st <= ST_WMIP;
          else if (miss_rd) st <= ST_RMIP;
        end
        ST_V, ST_E: begin
          if (inv_now) begin
            pend <= 1'b0;
            if (kv == 2'b00) st <= ST_I;
            else begin
              st  <= ST_INVIP;
              cnt <= {1'b0, kv[0]} + {1'b0, kv[1]};
              up  <= inv_src;
            end
          end else if (rinv_now) begin
            st <= ST_I;
            kv <= '0;
          end else begin
            if (victim) kv <= '0;
            if (miss_wr) st <= ST_WMIP;
            else if (miss_rd) st <= ST_RMIP;
            else if (victim) st <= ST_I;
          end
        end
        ST_RMIP: begin
          if (msg_inv && !pend) begin
            pend <= 1'b1;
            pend_src <= msg_inv_src;
          end
          if (msg_data) begin
            st <= ST_V;
            kv <= msg_kid_vld;
            ka <= msg_kid_a;
            kb <= msg_kid_b;
          end
        end
        ST_WMIP: begin
          if (msg_data) begin
            st <= ST_E;
            kv <= '0;
          end
        end
        ST_INVIP: begin
          if (msg_ack) begin
            if (cnt == 2'd1) begin
              st <= ST_I;
              kv <= '0;
              cnt <= '0;
            end else cnt <= cnt - 2'd1;
          end
        end
        default: st <= ST_I;
      endcase
    end
  end
endmodule

module tree_line_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       msg_data,
  input logic [1:0] msg_kid_vld,
  input logic       msg_ack,
  input logic       req_rd,
  input logic       req_wr,
  input logic [1:0] inv_out,
  input logic [1:0] rinv_out,
  input logic       ack_out,
  input logic [1:0] kid_vld,
  input logic [2:0] line_st
);
  // R2
  rd_req_enters_rmip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_rd |=> line_st == 3'd3);
  // R2
  one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_rd, req_wr}));
  // R3
  read_reply_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_st == 3'd3 && msg_data) |=> (line_st == 3'd1 && kid_vld == $past(msg_kid_vld)));
  // R5
  fanout_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_out != 2'b00) |=> line_st == 3'd5);
  // R6
  invip_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_st == 3'd5 && !msg_ack) |=> line_st == 3'd5);
  // R7
  rinv_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rinv_out != 2'b00) |-> !ack_out);
  // R10
  rmip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_st == 3'd3) |-> (!ack_out && inv_out == 2'b00));
endmodule

bind tree_line_ctl tree_line_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .msg_data(msg_data), .msg_kid_vld(msg_kid_vld),
  .msg_ack(msg_ack), .req_rd(req_rd), .req_wr(req_wr), .inv_out(inv_out),
  .rinv_out(rinv_out), .ack_out(ack_out), .kid_vld(kid_vld), .line_st(line_st)
);

// File: tb/test_tree_line_ctl.sv
module test_tree_line_ctl;
  localparam int PERIOD = 10;
  localparam int NW = 4;

  logic clk = 0, rst_n = 0;
  logic cpu_rd, cpu_wr, cpu_evict, msg_data, msg_inv, msg_rinv, msg_ack;
  logic [1:0] msg_kid_vld;
  logic [NW-1:0] msg_kid_a, msg_kid_b, msg_inv_src;
  logic req_rd, req_wr, ack_out;
  logic [1:0] inv_out, rinv_out, kid_vld;
  logic [NW-1:0] ack_dst, kid_a, kid_b;
  logic [2:0] line_st;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  tree_line_ctl #(.NODE_W(NW)) i_tree_line_ctl (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_evict(cpu_evict),
    .msg_data(msg_data), .msg_kid_vld(msg_kid_vld), .msg_kid_a(msg_kid_a), .msg_kid_b(msg_kid_b),
    .msg_inv(msg_inv), .msg_inv_src(msg_inv_src), .msg_rinv(msg_rinv), .msg_ack(msg_ack),
    .req_rd(req_rd), .req_wr(req_wr), .inv_out(inv_out), .rinv_out(rinv_out),
    .ack_out(ack_out), .ack_dst(ack_dst), .kid_a(kid_a), .kid_b(kid_b),
    .kid_vld(kid_vld), .line_st(line_st));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    cpu_rd = 0; cpu_wr = 0; cpu_evict = 0; msg_data = 0; msg_inv = 0;
    msg_rinv = 0; msg_ack = 0; msg_kid_vld = 0; msg_kid_a = 0; msg_kid_b = 0; msg_inv_src = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); clr(); #1;
  endtask

  task automatic do_reset();
    @(negedge clk); clr(); rst_n = 0; step(); rst_n = 1;
  endtask

  task automatic go_valid(int kv);
    do_reset();
    cpu_rd = 1; #1;
    chk("R2 req_rd", req_rd, 1);
    step();
    chk("R2 state", line_st, 3);
    msg_data = 1; msg_kid_vld = kv[1:0]; msg_kid_a = NW'(kv + 1); msg_kid_b = NW'(kv + 2);
    step();
    chk("R3 state", line_st, 1);
    chk("R3 kid_vld", kid_vld, kv);
    chk("R3 kid_a", kid_a, kv + 1);
    chk("R3 kid_b", kid_b, kv + 2);
  endtask

  task automatic drain(int kv, int src);
    int n = kv[0] + kv[1];
    for (int i = 0; i < n; i++) begin
      msg_ack = 1; #1;
      chk("R6 ack_out", ack_out, (i == n - 1) ? 1 : 0);
      if (i == n - 1) chk("R6 ack_dst", ack_dst, src);
      step();
    end
    chk("R6 final state", line_st, 0);
    chk("R6 kid_vld", kid_vld, 0);
  endtask

  task automatic take_inv(int kv, int src);
    #1;
    if (kv == 0) begin
      chk("R4 ack_out", ack_out, 1);
      chk("R4 ack_dst", ack_dst, src);
      chk("R4 inv_out", inv_out, 0);
    end else begin
      chk("R5 inv_out", inv_out, kv);
      chk("R5 ack_out", ack_out, 0);
    end
    step();
    chk("R4 R5 next state", line_st, (kv == 0) ? 0 : 5);
    if (kv != 0) drain(kv, src);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clr();
    do_reset();
    // R1
    chk("R1 line_st", line_st, 0);
    chk("R1 kid_vld", kid_vld, 0);
    chk("R1 outputs", {req_rd, req_wr, inv_out, rinv_out, ack_out}, 0);

    for (int kv = 0; kv < 4; kv++) begin
      go_valid(kv);
      msg_inv = 1; msg_inv_src = NW'(kv + 5);
      take_inv(kv, kv + 5);

      go_valid(kv);
      msg_rinv = 1; #1;
      chk("R7 rinv_out", rinv_out, kv);
      chk("R7 ack_out", ack_out, 0);
      step();
      chk("R7 state", line_st, 0);
      chk("R7 kid_vld", kid_vld, 0);

      go_valid(kv);
      cpu_rd = 1; cpu_evict = 1; #1;
      chk("R8 rinv_out", rinv_out, kv);
      chk("R8 req_rd", req_rd, 1);
      step();
      chk("R8 state rd", line_st, 3);

      go_valid(kv);
      cpu_evict = 1; #1;
      chk("R8 evict rinv_out", rinv_out, kv);
      chk("R8 evict no req", {req_rd, req_wr}, 0);
      step();
      chk("R8 evict state", line_st, 0);

      go_valid(kv);
      cpu_rd = 1; #1;
      chk("R9 read hit no req", {req_rd, req_wr, rinv_out}, 0);
      step();
      chk("R9 read hit state", line_st, 1);
      cpu_wr = 1; #1;
      chk("R9 upgrade rinv_out", rinv_out, kv);
      chk("R9 upgrade req_wr", req_wr, 1);
      step();
      chk("R9 upgrade state", line_st, 4);
      msg_inv = 1; msg_inv_src = 4'd7; #1;
      chk("R12 ack in wmip", ack_out, 1);
      chk("R12 ack_dst", ack_dst, 7);
      step();
      chk("R12 wmip state", line_st, 4);
      cpu_rd = 1; #1;
      chk("R11 wmip req ignored", {req_rd, req_wr}, 0);
      step();
      msg_data = 1; msg_kid_vld = 2'b11; step();
      chk("R3 excl state", line_st, 2);
      chk("R3 excl kids", kid_vld, 0);
      cpu_wr = 1; #1;
      chk("R9 excl write no req", {req_rd, req_wr, rinv_out}, 0);
      step();
      chk("R9 excl state", line_st, 2);

      do_reset();
      cpu_rd = 1; step();
      msg_inv = 1; msg_inv_src = 4'd9; #1;
      chk("R10 no ack in rmip", ack_out, 0);
      step();
      chk("R10 still rmip", line_st, 3);
      msg_data = 1; msg_kid_vld = kv[1:0]; #1;
      chk("R10 quiet on reply", {ack_out, inv_out}, 0);
      step();
      chk("R10 state valid", line_st, 1);
      take_inv(kv, 9);
    end

    go_valid(3);
    msg_rinv = 1; cpu_rd = 1; cpu_evict = 1; #1;
    chk("R11 rinv beats request", req_rd, 0);
    step();
    chk("R11 state", line_st, 0);
    go_valid(3);
    msg_inv = 1; msg_inv_src = 4'd2; cpu_wr = 1; #1;
    chk("R11 inv beats write", req_wr, 0);
    step();
    chk("R11 invip state", line_st, 5);
    cpu_rd = 1; #1;
    chk("R11 invip req ignored", req_rd, 0);
    step();
    drain(3, 2);
    cpu_rd = 1; step();
    cpu_wr = 1; #1;
    chk("R11 rmip req ignored", req_wr, 0);
    step();
    chk("R11 rmip state", line_st, 3);

    do_reset();
    msg_inv = 1; msg_inv_src = 4'd11; #1;
    chk("R12 stale ack", ack_out, 1);
    chk("R12 stale dst", ack_dst, 11);
    step();
    chk("R12 state", line_st, 0);
    msg_rinv = 1; #1;
    chk("R12 rinv ignored", {rinv_out, ack_out}, 0);
    step();
    chk("R12 rinv state", line_st, 0);
    cpu_wr = 1; #1;
    chk("R2 req_wr", req_wr, 1);
    step();
    chk("R2 wmip", line_st, 4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule